// File: doc/BRIEF.md
# Atomic Wide-Register Byte Bridge

This block joins an 8-bit processor bus to a bank of 16-bit peripheral registers. It makes every 16-bit transfer atomic, even though the bus moves only one byte per access. A single 8-bit holding register is shared by all wide slots and carries the upper half of each transfer. The lower-half access is the trigger. A lower-half write commits the held upper byte and the new lower byte to the target register on the same clock edge. A lower-half read returns the live lower byte and, on that same edge, captures the live upper byte into the holding register. The upper half is then read back from the holding register.

Software therefore writes the upper byte first and the lower byte second, and reads the lower byte first and the upper byte second. Each wide slot has a 16-bit output that drives peripheral logic and a 16-bit live input that the peripheral updates. A small set of plain 8-bit registers sits behind the same bus and never touches the holding register.

The address map is as follows, with N wide slots:
- Slot k has its lower byte at address 2k and its upper byte at address 2k+1.
- Byte register j sits at address 2N+j.
- Every higher address is unmapped.

Read data is registered and appears in the cycle after the read strobe.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, every wide output, every byte register, the holding register and `rd_data` are zero; an upper-byte read issued first returns 0.
- R2: A write to address 2k+1 loads `wr_data` into the holding register only; no wide output changes.
- R3: A write to address 2k sets wide output k to {holding register, `wr_data`} on the strobe's clock edge, with both halves changing in the same cycle.
- R4: A read of address 2k returns live_in[k][7:0] on `rd_data` in the next cycle and on the same edge stores live_in[k][15:8] in the holding register, so that a later change of the live input does not alter the upper half read afterwards.
- R5: A read of any address 2k+1 returns the holding register contents, whichever slot was read last.
- R6: The holding register is shared: an upper-byte write to slot a followed by a lower-byte write to slot b commits the byte written for slot a into slot b.
- R7: Byte register j at address 2N+j is written and read directly (read data the next cycle); neither access alters the holding register.
- R8: Writes to unmapped addresses change no output and no register; reads of them return 0.
- R9: If write and read strobes are both high, only the write is performed, and `rd_data` is 0 in the next cycle.
- R10: In any cycle following one without a read strobe, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte, valid the cycle after `rd_en` |
| wide_q | output | NUM_WIDE*16 | Wide register values, slot k at bits [16k+15:16k] |
| live_in | input | NUM_WIDE*16 | Live peripheral values, slot k at bits [16k+15:16k] |
| byte_q | output | NUM_BYTE*8 | Byte register values, register j at bits [8j+7:8j] |

## Verification
A corrupted holding register cannot be observed directly. It shows up only later: at the next lower-byte write, as a wrong upper half on a wide output, and at the next upper-byte read, as a wrong `rd_data` one cycle after the strobe. The bench therefore pairs every holding-register update with an access that exposes it straight away. The pairs covered are:
- an upper-byte write to one slot against a lower-byte write to another slot;
- a lower-byte read against upper-byte reads of every slot;
- a byte-register access inserted between the two halves.

A decode fault instead shows at once, as a wide or byte output changing on the edge of a write that should have left it alone.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_WLO  = 2'd1,
        ACC_WHI  = 2'd2,
        ACC_BYTE = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
    import wrb_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NUM_WIDE = 3,
    parameter int NUM_BYTE = 2,
    parameter int IDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned WIDE_END = 2 * NUM_WIDE;
    localparam int unsigned BYTE_END = WIDE_END + NUM_BYTE;

    logic [31:0] a_val;

    always_comb begin
        a_val = {{(32-ADDR_W){1'b0}}, addr};
        kind  = ACC_NONE;
        idx   = '0;
        if (a_val < WIDE_END) begin
            kind = addr[0] ? ACC_WHI : ACC_WLO;
            idx  = IDX_W'(a_val >> 1);
        end else if (a_val < BYTE_END) begin
            kind = ACC_BYTE;
            idx  = IDX_W'(a_val - WIDE_END);
        end
    end
endmodule

// File: rtl/wrb_wide_bank.sv
module wrb_wide_bank #(
    parameter int NUM_WIDE = 3,
    parameter int IDX_W    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              hold_hi,
    input  logic [7:0]              new_lo,
    output logic [NUM_WIDE*16-1:0]  wide_q
);
    for (genvar k = 0; k < NUM_WIDE; k++) begin : g_slot
        logic [15:0] val_d, val_q;
        logic        hit;

        always_comb begin
            hit   = commit && (idx == IDX_W'(k));
            val_d = val_q;
            if (hit) begin
                val_d = {hold_hi, new_lo};
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign wide_q[k*16 +: 16] = val_q;

        // R3
        commit_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && idx == IDX_W'(k)) |=> (val_q == {$past(hold_hi), $past(new_lo)}));
    end
endmodule

// File: rtl/wrb_byte_bank.sv
module wrb_byte_bank #(
    parameter int NUM_BYTE = 2,
    parameter int IDX_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [7:0]             wdata,
    output logic [7:0]             rd_sel,
    output logic [NUM_BYTE*8-1:0]  byte_q
);
    for (genvar j = 0; j < NUM_BYTE; j++) begin : g_reg
        logic [7:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (we && idx == IDX_W'(j)) begin
                val_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign byte_q[j*8 +: 8] = val_q;
    end

    always_comb begin
        rd_sel = '0;
        for (int j = 0; j < NUM_BYTE; j++) begin
            if (idx == IDX_W'(j)) rd_sel = byte_q[j*8 +: 8];
        end
    end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
    import wrb_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NUM_WIDE = 3,
    parameter int NUM_BYTE = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wr_data,
    input  logic                   wr_en,
    input  logic                   rd_en,
    output logic [7:0]             rd_data,
    output logic [NUM_WIDE*16-1:0] wide_q,
    input  logic [NUM_WIDE*16-1:0] live_in,
    output logic [NUM_BYTE*8-1:0]  byte_q
);
    localparam int MAX_CNT = (NUM_WIDE > NUM_BYTE) ? NUM_WIDE : NUM_BYTE;
    localparam int IDX_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;

    typedef struct packed {
        logic [7:0] hold;
        logic [7:0] rdata;
    } state_t;

    state_t          st_d, st_q;
    acc_kind_e       kind;
    logic [IDX_W-1:0] idx;
    logic [15:0]     live_sel;
    logic [7:0]      byte_rd;
    logic            commit;
    logic            byte_we;

    wrb_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_WIDE(NUM_WIDE),
        .NUM_BYTE(NUM_BYTE),
        .IDX_W   (IDX_W)
    ) u_decode (
        .addr(addr),
        .kind(kind),
        .idx (idx)
    );

    always_comb begin
        live_sel = '0;
        for (int k = 0; k < NUM_WIDE; k++) begin
            if (idx == IDX_W'(k)) live_sel = live_in[k*16 +: 16];
        end
    end

    assign commit  = wr_en && (kind == ACC_WLO);
    assign byte_we = wr_en && (kind == ACC_BYTE);

    wrb_wide_bank #(
        .NUM_WIDE(NUM_WIDE),
        .IDX_W   (IDX_W)
    ) u_wide (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .idx    (idx),
        .hold_hi(st_q.hold),
        .new_lo (wr_data),
        .wide_q (wide_q)
    );

    wrb_byte_bank #(
        .NUM_BYTE(NUM_BYTE),
        .IDX_W   (IDX_W)
    ) u_bytes (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (byte_we),
        .idx   (idx),
        .wdata (wr_data),
        .rd_sel(byte_rd),
        .byte_q(byte_q)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (wr_en) begin
            if (kind == ACC_WHI) st_d.hold = wr_data;
        end else if (rd_en) begin
            unique case (kind)
                ACC_WLO: begin
                    st_d.rdata = live_sel[7:0];
                    st_d.hold  = live_sel[15:8];
                end
                ACC_WHI:  st_d.rdata = st_q.hold;
                ACC_BYTE: st_d.rdata = byte_rd;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;

    // R2
    hi_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_WHI) |=> $stable(wide_q));

    // R4
    lo_read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && kind == ACC_WLO) |=> (st_q.hold == $past(live_sel[15:8])));

    // R5
    hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && kind == ACC_WHI) |=> (rd_data == $past(st_q.hold)));

    // R7
    byte_hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && kind == ACC_BYTE) |=> $stable(st_q.hold));

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_NONE) |=> ($stable(wide_q) && $stable(byte_q)));

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == 8'h00));
endmodule

// File: tb/wide_reg_bridge_tb.sv
module wide_reg_bridge_tb;
    localparam int AW = 4;
    localparam int NW = 3;
    localparam int NB = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [AW-1:0]   addr;
    logic [7:0]      wr_data;
    logic            wr_en, rd_en;
    logic [7:0]      rd_data;
    logic [NW*16-1:0] wide_q;
    logic [NW*16-1:0] live_in;
    logic [NB*8-1:0] byte_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wide_reg_bridge #(.ADDR_W(AW), .NUM_WIDE(NW), .NUM_BYTE(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .wide_q(wide_q), .live_in(live_in), .byte_q(byte_q)
    );

    logic [15:0] exp_wide [NW];
    logic [7:0]  exp_byte [NB];

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic r, input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = w; rd_en = r; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic chk_all(input string tag);
        for (int k = 0; k < NW; k++) chk(tag, wide_q[k*16 +: 16], exp_wide[k]);
        for (int j = 0; j < NB; j++) chk(tag, {8'h00, byte_q[j*8 +: 8]}, {8'h00, exp_byte[j]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
        live_in = '0;
        for (int k = 0; k < NW; k++) exp_wide[k] = '0;
        for (int j = 0; j < NB; j++) exp_byte[j] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_all("R1 reset outputs");
        chk("R1 reset rd_data", {8'h00, rd_data}, 16'h0);
        acc(1'b0, 1'b1, AW'(1), 8'h00);
        chk("R1 reset hold via hi read", {8'h00, rd_data}, 16'h0);

        // R2 then R3 per slot
        for (int k = 0; k < NW; k++) begin
            acc(1'b1, 1'b0, AW'(2*k+1), 8'hA0 + 8'(k));
            chk_all("R2 hi write leaves outputs");
            acc(1'b1, 1'b0, AW'(2*k), 8'(5*k+3));
            exp_wide[k] = {8'hA0 + 8'(k), 8'(5*k+3)};
            chk_all("R3 lo write commits pair");
        end

        // R6 shared holding register across all slot pairs
        for (int a = 0; a < NW; a++) begin
            for (int b = 0; b < NW; b++) begin
                acc(1'b1, 1'b0, AW'(2*a+1), 8'(16*a + b + 1));
                acc(1'b1, 1'b0, AW'(2*b), 8'(8'hF0 - 8'(a*NW+b)));
                exp_wide[b] = {8'(16*a + b + 1), 8'(8'hF0 - 8'(a*NW+b))};
                chk_all("R6 shared hold commit");
            end
        end

        // R4 / R5 reads
        for (int k = 0; k < NW; k++) begin
            for (int m = 0; m < NW; m++) live_in[m*16 +: 16] = 16'(16'h1111 * (m+1) + 16'(k*7));
            acc(1'b0, 1'b1, AW'(2*k), 8'h00);
            chk("R4 lo read live byte", {8'h00, rd_data}, {8'h00, 8'(16'h1111*(k+1) + 16'(k*7))});
            live_in = ~live_in;
            for (int m = 0; m < NW; m++) begin
                acc(1'b0, 1'b1, AW'(2*m+1), 8'h00);
                chk("R5 hi read returns captured", {8'h00, rd_data},
                    {8'h00, 8'((16'h1111*(k+1) + 16'(k*7)) >> 8)});
            end
        end

        // R7 byte registers do not disturb holding register
        acc(1'b1, 1'b0, AW'(1), 8'h5C);
        for (int j = 0; j < NB; j++) begin
            acc(1'b1, 1'b0, AW'(2*NW + j), 8'h30 + 8'(j));
            exp_byte[j] = 8'h30 + 8'(j);
            acc(1'b0, 1'b1, AW'(2*NW + j), 8'h00);
            chk("R7 byte read", {8'h00, rd_data}, {8'h00, exp_byte[j]});
        end
        acc(1'b1, 1'b0, AW'(0), 8'h77);
        exp_wide[0] = 16'h5C77;
        chk_all("R7 hold kept across byte access");

        // R8 unmapped addresses
        for (int a = 2*NW + NB; a < (1 << AW); a++) begin
            acc(1'b1, 1'b0, AW'(a), 8'hEE);
            chk_all("R8 unmapped write ignored");
            acc(1'b0, 1'b1, AW'(a), 8'h00);
            chk("R8 unmapped read zero", {8'h00, rd_data}, 16'h0);
        end
        acc(1'b1, 1'b0, AW'(0), 8'h01);
        exp_wide[0] = 16'h5C01;
        chk_all("R8 hold kept across unmapped write");

        // R9 both strobes: write done, read dropped
        acc(1'b1, 1'b1, AW'(2*NW), 8'h9D);
        exp_byte[0] = 8'h9D;
        chk("R9 rd_data zero on collision", {8'h00, rd_data}, 16'h0);
        chk_all("R9 write performed");

        // R10 idle cycle clears rd_data
        acc(1'b0, 1'b1, AW'(2*NW), 8'h00);
        chk("R10 read before idle", {8'h00, rd_data}, 16'h009D);
        @(negedge clk);
        chk("R10 idle rd_data zero", {8'h00, rd_data}, 16'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule